// File: doc/BRIEF.md
# Four-Sequencer Sample FIFO Controller

This block is the digital front end of a sampling converter with four independent sample sequencers. Each sequencer owns a sixteen-entry result queue. A rising edge on the trigger input, which comes from a periodic timer, pushes one new sample into every sequencer that is switched on and whose event selector picks the timer as its source. The analog conversion is stood in for by a pseudo-random generator, so each sample is a fixed mid-scale value with a small random offset.

Software reaches the block through a simple register bus. A read of a sequencer's pop register removes the oldest sample from that queue. A separate status word shows the queue's read pointer, write pointer, empty flag and full flag. Every accepted sample sets a raw event bit for its sequencer. Each of the four interrupt lines is that raw bit gated by a mask bit.

Top module: `smpseq_ctl`

## Requirements
- R1: After reset every queue is empty with both pointers at zero, so each status word reads 0x00000100. The active, mask, event-select, raw-event, input-select and control registers all read zero, every interrupt output is low and the noise state is zero.
- R2: The per-sequencer status word holds the read pointer in bits [3:0], the write pointer in bits [7:4], the empty flag in bit 8 and the full flag in bit 12. All other bits read zero, and empty and full are never set together.
- R3: A push into a full queue is discarded and changes nothing. Otherwise the sample is stored at the write pointer, the write pointer advances modulo 16, empty clears, and full sets when the new write pointer equals the read pointer. Samples leave the queue in arrival order.
- R4: A pop from an empty queue leaves both pointers unchanged and returns the last value that was popped from that queue (zero if none). Otherwise the pop returns the entry at the read pointer, the read pointer advances modulo 16, full clears, and empty sets when the new read pointer equals the write pointer.
- R5: On a trigger, sequencer n takes a sample only if bit n of the active register (offset 0x00, bits [3:0]) is 1 and its event field, bits [4n+3:4n] of the event-select register (offset 0x14), equals 5.
- R6: The trigger input is edge-detected. One rising edge gives exactly one sample per qualifying sequencer, however long the input stays high.
- R7: Before each sample, the 32-bit noise state is replaced by noise × 314159 + 1, with the product wrapping at 32 bits. The sample is 0x200 plus bits [18:16] of the new state. When several sequencers qualify on one trigger, they take their updates in ascending sequencer order.
- R8: Sequencer n's registers sit at 0x40 + 0x20·n: input-select at +0x00, control at +0x04, pop at +0x08 and status at +0x0C. The input-select register keeps only the bits in mask 0x33333333. The control register stores all 32 bits.
- R9: An accepted push sets bit n of the raw-event register (offset 0x04). Writing 1 to bit n at offset 0x0C clears it. A read of 0x0C returns raw AND mask.
- R10: Interrupt output n is high exactly when raw-event bit n and mask bit n (offset 0x08, bits [3:0]) are both 1.
- R11: The active and mask registers store 4 bits and the event-select register stores 16 bits. Upper write bits are dropped and read back as zero.
- R12: Read data appears on bus_rdata at the clock edge that takes the read and holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig_in | input | 1 | Timer trigger, rising edge active |
| irq_o | output | 4 | Per-sequencer interrupt lines |

## Verification
The bench builds the block with its default parameters: four sequencers, sixteen-deep queues and 4-bit event fields. With these values the pointer wrap, the full queue and a dropped push can all be reached with a few dozen triggers. At the same defaults, a single trigger can make some sequencers sample while others skip, so the ascending order of noise updates can be observed. A reference model of the queues and the noise recurrence, written from the requirements, predicts every popped value and status word.

// File: rtl/smpseq_pkg.sv
package smpseq_pkg;

    localparam int SMP_W      = 12;
    localparam int NOISE_W    = 32;
    localparam int JIT_LSB    = 16;
    localparam int JIT_W      = 3;
    localparam logic [NOISE_W-1:0] NOISE_MUL = 32'd314159;
    localparam logic [SMP_W-1:0]   SMP_BASE  = 12'h200;
    localparam logic [31:0]        MUX_KEEP  = 32'h3333_3333;

    localparam logic [7:0] OFF_ACT   = 8'h00;
    localparam logic [7:0] OFF_RAW   = 8'h04;
    localparam logic [7:0] OFF_MASK  = 8'h08;
    localparam logic [7:0] OFF_MSTAT = 8'h0C;
    localparam logic [7:0] OFF_EVT   = 8'h14;
    localparam int         SEQ_BASE  = 'h40;
    localparam int         SEQ_SHIFT = 5;

    typedef enum logic [2:0] {
        G_NONE, G_ACT, G_RAW, G_MASK, G_MSTAT, G_EVT
    } greg_e;

    typedef enum logic [1:0] {
        F_MUX = 2'd0, F_CTL = 2'd1, F_POP = 2'd2, F_STAT = 2'd3
    } sfield_e;

    typedef struct packed {
        logic       full;
        logic       empty;
        logic [3:0] head;
        logic [3:0] tail;
    } fstat_t;

    function automatic logic [NOISE_W-1:0] noise_next(input logic [NOISE_W-1:0] x);
        return x * NOISE_MUL + 1'b1;
    endfunction

    function automatic logic [SMP_W-1:0] noise_sample(input logic [NOISE_W-1:0] x);
        return SMP_BASE + SMP_W'(x[JIT_LSB +: JIT_W]);
    endfunction

    function automatic logic [31:0] pack_status(input fstat_t s);
        return {19'd0, s.full, 3'd0, s.empty, s.head, s.tail};
    endfunction

endpackage

// File: rtl/smpseq_fifo.sv
module smpseq_fifo
    import smpseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = SMP_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             empty,
    output logic             full,
    output logic             accepted
);
    logic [W-1:0]     mem [DEPTH];
    logic [W-1:0]     last_q;
    logic             pop_ok;
    logic [PTR_W-1:0] tail_mid, head_nx, tail_inc, head_inc;
    logic             empty_mid, full_mid, empty_nx, full_nx;

    assign tail_inc = tail + 1'b1;
    assign head_inc = head + 1'b1;

    // pop is resolved first, then the push sees the post-pop state
    always_comb begin
        pop_ok    = pop && !empty;
        tail_mid  = pop_ok ? tail_inc : tail;
        full_mid  = pop_ok ? 1'b0 : full;
        empty_mid = pop_ok ? (tail_inc == head) : empty;
        accepted  = push && !full_mid;
        head_nx   = accepted ? head_inc : head;
        empty_nx  = accepted ? 1'b0 : empty_mid;
        full_nx   = accepted ? (head_inc == tail_mid) : full_mid;
        pop_data  = pop_ok ? mem[tail] : last_q;
    end

    always_ff @(posedge clk) begin
        if (accepted) mem[head] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head   <= '0;
            tail   <= '0;
            empty  <= 1'b1;
            full   <= 1'b0;
            last_q <= '0;
        end else begin
            head  <= head_nx;
            tail  <= tail_mid;
            empty <= empty_nx;
            full  <= full_nx;
            if (pop_ok) last_q <= mem[tail];
        end
    end
endmodule

// File: rtl/smpseq_trig.sv
module smpseq_trig
    import smpseq_pkg::*;
#(
    parameter int N_SEQ     = 4,
    parameter int EVT_W     = 4,
    parameter int EVT_TIMER = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trig_in,
    input  logic [N_SEQ-1:0]       act,
    input  logic [N_SEQ*EVT_W-1:0] evt_sel,
    output logic [N_SEQ-1:0]       push_req,
    output logic [SMP_W-1:0]       push_data [N_SEQ]
);
    logic               trig_q;
    logic               rise;
    logic [NOISE_W-1:0] noise_q;
    logic [NOISE_W-1:0] chain [N_SEQ+1];

    assign rise     = trig_in && !trig_q;
    assign chain[0] = noise_q;

    for (genvar i = 0; i < N_SEQ; i++) begin : g_seq
        logic qual;
        assign qual         = act[i] && (evt_sel[i*EVT_W +: EVT_W] == EVT_W'(EVT_TIMER));
        assign push_req[i]  = rise && qual;
        assign chain[i+1]   = push_req[i] ? noise_next(chain[i]) : chain[i];
        assign push_data[i] = noise_sample(chain[i+1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= 1'b0;
            noise_q <= '0;
        end else begin
            trig_q  <= trig_in;
            noise_q <= chain[N_SEQ];
        end
    end
endmodule

// File: rtl/smpseq_ctl.sv
module smpseq_ctl
    import smpseq_pkg::*;
#(
    parameter int N_SEQ     = 4,
    parameter int DEPTH     = 16,
    parameter int EVT_W     = 4,
    parameter int EVT_TIMER = 5,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              trig_in,
    output logic [N_SEQ-1:0]  irq_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int IDX_W = $clog2(N_SEQ);
    localparam int EVT_T = N_SEQ * EVT_W;
    localparam logic [ADDR_W:0] SEQ_LO = (ADDR_W+1)'(SEQ_BASE);
    localparam logic [ADDR_W:0] SEQ_HI = (ADDR_W+1)'(SEQ_BASE + (N_SEQ << SEQ_SHIFT));

    logic [N_SEQ-1:0] act_q, mask_q, raw_q, raw_clr;
    logic [EVT_T-1:0] evt_q;
    logic [31:0]      mux_q [N_SEQ];
    logic [31:0]      ctl_q [N_SEQ];

    logic [N_SEQ-1:0] push_req, pushed_v, pop_v, empty_v, full_v;
    logic [SMP_W-1:0] push_data [N_SEQ];
    logic [SMP_W-1:0] pop_data  [N_SEQ];
    logic [PTR_W-1:0] head_v    [N_SEQ];
    logic [PTR_W-1:0] tail_v    [N_SEQ];

    logic              rd_en, wr_en, seq_hit;
    logic [ADDR_W-1:0] seq_off;
    logic [IDX_W-1:0]  seq_idx;
    sfield_e           field;
    greg_e             g_sel;
    fstat_t            stat_sel;
    logic [31:0]       rd_next;

    assign rd_en   = bus_sel && !bus_wr;
    assign wr_en   = bus_sel && bus_wr;
    assign seq_off = bus_addr - ADDR_W'(SEQ_BASE);
    assign seq_hit = ({1'b0, bus_addr} >= SEQ_LO) && ({1'b0, bus_addr} < SEQ_HI) && !seq_off[4];
    assign seq_idx = seq_off[SEQ_SHIFT +: IDX_W];
    assign field   = sfield_e'(seq_off[3:2]);

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_ACT))   g_sel = G_ACT;
        else if (bus_addr == ADDR_W'(OFF_RAW))   g_sel = G_RAW;
        else if (bus_addr == ADDR_W'(OFF_MASK))  g_sel = G_MASK;
        else if (bus_addr == ADDR_W'(OFF_MSTAT)) g_sel = G_MSTAT;
        else if (bus_addr == ADDR_W'(OFF_EVT))   g_sel = G_EVT;
        else                                     g_sel = G_NONE;
    end

    smpseq_trig #(
        .N_SEQ(N_SEQ), .EVT_W(EVT_W), .EVT_TIMER(EVT_TIMER)
    ) u_trig (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .act(act_q), .evt_sel(evt_q),
        .push_req(push_req), .push_data(push_data)
    );

    for (genvar i = 0; i < N_SEQ; i++) begin : g_q
        assign pop_v[i] = rd_en && seq_hit && (seq_idx == IDX_W'(i)) && (field == F_POP);
        smpseq_fifo #(.DEPTH(DEPTH), .W(SMP_W)) u_fifo (
            .clk(clk), .rst(rst),
            .push(push_req[i]), .push_data(push_data[i]),
            .pop(pop_v[i]), .pop_data(pop_data[i]),
            .head(head_v[i]), .tail(tail_v[i]),
            .empty(empty_v[i]), .full(full_v[i]),
            .accepted(pushed_v[i])
        );
    end

    assign raw_clr = (wr_en && g_sel == G_MSTAT) ? bus_wdata[N_SEQ-1:0] : '0;
    assign irq_o   = raw_q & mask_q;

    always_comb begin
        stat_sel.full  = full_v[seq_idx];
        stat_sel.empty = empty_v[seq_idx];
        stat_sel.head  = 4'(head_v[seq_idx]);
        stat_sel.tail  = 4'(tail_v[seq_idx]);
        rd_next = '0;
        case (g_sel)
            G_ACT:   rd_next = 32'(act_q);
            G_RAW:   rd_next = 32'(raw_q);
            G_MASK:  rd_next = 32'(mask_q);
            G_MSTAT: rd_next = 32'(raw_q & mask_q);
            G_EVT:   rd_next = 32'(evt_q);
            default: rd_next = '0;
        endcase
        if (seq_hit) begin
            case (field)
                F_MUX:  rd_next = mux_q[seq_idx];
                F_CTL:  rd_next = ctl_q[seq_idx];
                F_POP:  rd_next = 32'(pop_data[seq_idx]);
                F_STAT: rd_next = pack_status(stat_sel);
                default: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= '0;
            mask_q    <= '0;
            raw_q     <= '0;
            evt_q     <= '0;
            bus_rdata <= '0;
            for (int i = 0; i < N_SEQ; i++) begin
                mux_q[i] <= '0;
                ctl_q[i] <= '0;
            end
        end else begin
            raw_q <= (raw_q & ~raw_clr) | pushed_v;
            if (rd_en) bus_rdata <= rd_next;
            if (wr_en) begin
                case (g_sel)
                    G_ACT:  act_q  <= bus_wdata[N_SEQ-1:0];
                    G_MASK: mask_q <= bus_wdata[N_SEQ-1:0];
                    G_EVT:  evt_q  <= bus_wdata[EVT_T-1:0];
                    default: ;
                endcase
                if (seq_hit && field == F_MUX) mux_q[seq_idx] <= bus_wdata & MUX_KEEP;
                if (seq_hit && field == F_CTL) ctl_q[seq_idx] <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/smpseq_ctl_chk.sv
module smpseq_ctl_chk #(
    parameter int N_SEQ = 4,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SEQ-1:0] push_req,
    input logic [N_SEQ-1:0] pop_v,
    input logic [N_SEQ-1:0] empty_v,
    input logic [N_SEQ-1:0] full_v,
    input logic [PTR_W-1:0] head_v [N_SEQ],
    input logic [PTR_W-1:0] tail_v [N_SEQ],
    input logic [N_SEQ-1:0] act_q,
    input logic [N_SEQ-1:0] mask_q,
    input logic [N_SEQ-1:0] irq_o
);
    for (genvar i = 0; i < N_SEQ; i++) begin : g_chk
        // R2
        flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(empty_v[i] && full_v[i]));
        // R3
        push_adv_chk: assert property (@(posedge clk) disable iff (rst)
            (push_req[i] && !full_v[i] && !pop_v[i]) |=>
                (head_v[i] == PTR_W'($past(head_v[i]) + 1'b1)) && !empty_v[i]);
        // R3
        drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (push_req[i] && full_v[i] && !pop_v[i]) |=> $stable(head_v[i]) && full_v[i]);
        // R4
        empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
            (pop_v[i] && empty_v[i] && !push_req[i]) |=> $stable(tail_v[i]) && $stable(head_v[i]));
        // R5
        qualify_chk: assert property (@(posedge clk) disable iff (rst)
            push_req[i] |-> act_q[i]);
        // R6
        one_shot_chk: assert property (@(posedge clk) disable iff (rst)
            push_req[i] |=> !push_req[i]);
        // R10
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> mask_q[i]);
    end
endmodule

bind smpseq_ctl smpseq_ctl_chk #(.N_SEQ(N_SEQ), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_v(pop_v),
    .empty_v(empty_v), .full_v(full_v), .head_v(head_v), .tail_v(tail_v),
    .act_q(act_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/smpseq_ctl_test.sv
module smpseq_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    smpseq_ctl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .irq_o(irq_o)
    );

    // reference model
    logic [31:0] m_noise;
    logic [11:0] m_data [4][16];
    int          m_rd [4];
    int          m_wr [4];
    int          m_cnt [4];
    logic [11:0] m_last [4];
    logic [3:0]  m_act;
    logic [15:0] m_evt;

    // {addr, write value, expected read-back}
    localparam logic [71:0] VEC [7] = '{
        {8'h40, 32'hFFFF_FFFF, 32'h3333_3333},
        {8'h60, 32'h1234_5678, 32'h1230_1230},
        {8'hA4, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h44, 32'h0000_A5A5, 32'h0000_A5A5},
        {8'h00, 32'hFFFF_FFFF, 32'h0000_000F},
        {8'h08, 32'hFFFF_FFF3, 32'h0000_0003},
        {8'h14, 32'hABCD_5555, 32'h0000_5555}
    };

    function automatic logic [31:0] nx(input logic [31:0] x);
        return x * 32'd314159 + 32'd1;
    endfunction

    task automatic model_reset();
        m_noise = '0; m_act = '0; m_evt = '0;
        for (int n = 0; n < 4; n++) begin
            m_rd[n] = 0; m_wr[n] = 0; m_cnt[n] = 0; m_last[n] = '0;
        end
    endtask

    function automatic logic [31:0] model_stat(input int n);
        logic [3:0] r, w;
        r = 4'(m_rd[n]);
        w = 4'(m_wr[n]);
        return {19'd0, (m_cnt[n] == 16), 3'd0, (m_cnt[n] == 0), w, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_act(input logic [3:0] v);
        wr(8'h00, 32'(v)); m_act = v;
    endtask

    task automatic set_evt(input logic [15:0] v);
        wr(8'h14, 32'(v)); m_evt = v;
    endtask

    task automatic model_trig();
        for (int n = 0; n < 4; n++) begin
            if (m_act[n] && m_evt[4*n +: 4] == 4'd5) begin
                m_noise = nx(m_noise);
                if (m_cnt[n] < 16) begin
                    m_data[n][m_wr[n]] = 12'h200 + 12'(m_noise[18:16]);
                    m_wr[n] = (m_wr[n] + 1) % 16;
                    m_cnt[n]++;
                end
            end
        end
    endtask

    task automatic pulse(input int hold);
        @(negedge clk);
        trig_in = 1'b1;
        for (int k = 0; k < hold; k++) @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        model_trig();
    endtask

    task automatic pop_check(input int n, input string req);
        logic [31:0] d;
        logic [11:0] e;
        if (m_cnt[n] > 0) begin
            e = m_data[n][m_rd[n]];
            m_rd[n] = (m_rd[n] + 1) % 16;
            m_cnt[n]--;
            m_last[n] = e;
        end else e = m_last[n];
        rd(8'h48 + 8'(n * 32), d);
        check(req, d, 32'(e));
    endtask

    task automatic stat_check(input int n, input string req);
        logic [31:0] d;
        rd(8'h4C + 8'(n * 32), d);
        check(req, d, model_stat(n));
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int n = 0; n < 4; n++) stat_check(n, "R1 status after reset");
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(8'h04, d); check("R1 raw after reset", d, 32'h0);
        rd(8'h40, d); check("R1 input-select after reset", d, 32'h0);

        // R8 R11 R12 register table
        for (int v = 0; v < 7; v++) begin
            wr(VEC[v][71:64], VEC[v][63:32]);
            rd(VEC[v][71:64], d);
            check("R8 R11 R12 table", d, VEC[v][31:0]);
        end
        m_act = 4'hF; m_evt = 16'h5555;
        rd(8'h10, d); check("R12 unmapped reads zero", d, 32'h0);

        // R5 qualification: seq2 wrong event, seq3 inactive
        set_evt(16'h5355);
        set_act(4'b0111);
        pulse(1);
        for (int n = 0; n < 4; n++) stat_check(n, "R5 R2 status after trigger");

        // R9 R10 raw, masked view and interrupts (mask = 3)
        rd(8'h04, d); check("R9 raw after push", d, 32'h3);
        check("R10 irq", 32'(irq_o), 32'h3);
        wr(8'h0C, 32'h1);
        rd(8'h04, d); check("R9 write-one clear", d, 32'h2);
        rd(8'h0C, d); check("R9 masked read", d, 32'h2);
        check("R10 irq after clear", 32'(irq_o), 32'h2);
        wr(8'h08, 32'h0);
        check("R10 irq masked off", 32'(irq_o), 32'h0);

        // R7 sample values, ascending order
        pop_check(0, "R7 sample seq0");
        pop_check(1, "R7 sample seq1");
        stat_check(0, "R4 status after pop");
        // R4 pop on empty
        pop_check(0, "R4 empty pop returns last");
        stat_check(0, "R4 empty pop keeps pointers");

        // R6 held trigger gives one sample
        set_act(4'b0001);
        pulse(6);
        stat_check(0, "R6 one sample per edge");

        // R3 fill to full, then one dropped push
        for (int k = 0; k < 15; k++) pulse(1);
        stat_check(0, "R3 full after wrap");
        pulse(1);
        stat_check(0, "R3 push into full dropped");
        for (int k = 0; k < 16; k++) pop_check(0, "R3 R7 arrival order");
        stat_check(0, "R4 empty after drain");

        // R1 reset mid-run restores state and noise
        pulse(1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        stat_check(0, "R1 status after second reset");
        rd(8'h00, d); check("R1 active after reset", d, 32'h0);
        set_evt(16'h0005);
        set_act(4'b0001);
        pulse(1);
        pop_check(0, "R1 R7 noise restarts");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule